// File: doc/BRIEF.md
# Layer-Major Spiking Network Sequencer

This block steps a feed-forward spiking network through its computation one layer at a time. A layer runs through every timestep before the next layer begins. Each timestep has two phases. In the first, the sequencer scans the spike bitmap that the layer before wrote for that same timestep. It hands each set bit to one of the propagation lanes, as a spike that carries the source neuron index. In the second, once every spike has gone out and every lane reports that it is quiet, it sweeps all neurons of the current layer through an integrate-and-fire step. It writes the potentials back to state memory and records the new spikes in the spike bitmap.

The spike bitmap has two banks. Layer `l` reads the bank `l % 2` and writes the other bank, so a layer never overwrites its own input. The host places the input-layer spikes in bank 0 before it pulses `start`. Each lane has a valid/ready input port. `lane_valid` is one-hot or zero. Once raised, it stays high with `lane_nid` and `lane_prob` unchanged until the selected lane's ready bit is sampled high at a clock edge. A spike is never dropped.

Top module: `snn_layer_seq`

## Requirements
- R1: While reset is held, `done`, `lane_valid`, `sp_rd_en`, `sp_wr_en`, `st_rd_en` and `st_wr_en` are all low.
- R2: After `start`, the layers 0..`cfg_last_layer` run in ascending order. Each layer runs all timesteps 0..`cfg_last_ts` in ascending order before the next layer begins.
- R3: Within a timestep, no state read of the evaluation sweep is issued until every set spike of that timestep has been accepted by a lane and `lane_busy` is all zero.
- R4: Propagation reads the bitmap at address {bank = layer bit 0, timestep (TW bits), neuron (NW bits)}, MSB first, for neurons 0 up to the previous layer's last index. The previous layer's last index is the `cfg_size` slice `l` (NW bits each; slice 0 is the input layer, slice `l+1` is layer `l`). Set bits are dispatched in ascending neuron order, each to lane `neuron % LANES`, with `lane_nid` = neuron.
- R5: `lane_valid` is one-hot or zero. A raised valid holds, with stable `lane_nid`, until that lane's `lane_ready` is high at a clock edge. Every dispatched spike is accepted exactly once.
- R6: For each neuron `n` of layer `l`, in ascending order, the sweep reads state address {l (LW bits), n (NW bits)} and forms sum = potential + bias, signed and VW bits wide. If sum > threshold (strictly greater), the neuron fires and 0 is written back; otherwise sum is written back. The write goes to the same address in the cycle after the read.
- R7: For each neuron of the sweep, the fire bit (1 = fired, 0 = not) is written to bitmap address {not(layer bit 0), timestep, neuron}. This covers silent neurons too.
- R8: During the dispatches of layer `l`, `lane_prob` equals bit `l` of `cfg_prob`.
- R9: `done` is high for exactly one cycle after the last timestep of layer `cfg_last_layer`. A `start` that arrives while a run is in progress has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (used only when idle) |
| done | output | 1 | One-cycle pulse at the end of the run |
| cfg_last_layer | input | LW | Index of the last layer to evaluate |
| cfg_last_ts | input | TW | Index of the last timestep |
| cfg_size | input | (MAXL+1)*NW | Last neuron index per layer; slice 0 is the input layer |
| cfg_prob | input | MAXL | Propagation mode per layer (1 = probabilistic) |
| cfg_thresh | input | MAXL*VW | Signed firing threshold per layer |
| cfg_bias | input | MAXL*VW | Signed bias per layer |
| sp_rd_en | output | 1 | Spike bitmap read strobe |
| sp_rd_addr | output | 1+TW+NW | Spike bitmap read address |
| sp_rd_data | input | 1 | Bitmap bit, one cycle after the strobe |
| sp_wr_en | output | 1 | Spike bitmap write strobe |
| sp_wr_addr | output | 1+TW+NW | Spike bitmap write address |
| sp_wr_data | output | 1 | Fire bit to store |
| lane_valid | output | LANES | Per-lane spike valid |
| lane_ready | input | LANES | Per-lane queue ready |
| lane_nid | output | NW | Source neuron of the offered spike |
| lane_prob | output | 1 | Propagation mode of the current layer |
| lane_busy | input | LANES | Lane holds or is processing spikes |
| st_rd_en | output | 1 | State memory read strobe |
| st_rd_addr | output | LW+NW | State read address {layer, neuron} |
| st_rd_data | input | VW | Potential, one cycle after the strobe |
| st_wr_en | output | 1 | State write strobe |
| st_wr_addr | output | LW+NW | State write address |
| st_wr_data | output | VW | Potential to store |

## Verification
Several properties are checked on every clock cycle:
- the one-hot lane valid, and the hold of an offered spike under back-pressure;
- the rule that no state read overlaps a busy lane or a bitmap read;
- each write-back landing one cycle after its read;
- the layer index moving only upward or back to zero;
- the single-cycle `done`.

Only the scenarios can show the rest: the exact order of layers, timesteps and neurons, that no spike is lost or duplicated under random lane stalls, the strict threshold comparison at equality, the bank alternation in the final bitmap, and that a stray `start` mid-run is ignored.

// File: rtl/snn_seq_pkg.sv
package snn_seq_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_PROP, SQ_SETTLE, SQ_DRAIN, SQ_EVAL, SQ_NEXT
  } seq_state_t;

  typedef enum logic [1:0] {
    DP_IDLE, DP_READ, DP_TEST, DP_SEND
  } disp_state_t;

  typedef enum logic [1:0] {
    EV_IDLE, EV_READ, EV_FIRE
  } eval_state_t;
endpackage

// File: rtl/snn_spike_dispatch.sv
module snn_spike_dispatch
  import snn_seq_pkg::*;
#(
  parameter int LANES = 16,
  parameter int NW    = 6,
  parameter int TW    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic               bank,
  input  logic [TW-1:0]      ts,
  input  logic [NW-1:0]      last_idx,
  output logic               sp_rd_en,
  output logic [TW+NW:0]     sp_rd_addr,
  input  logic               sp_rd_data,
  output logic [LANES-1:0]   lane_valid,
  input  logic [LANES-1:0]   lane_ready,
  output logic [NW-1:0]      lane_nid,
  output logic               finished
);
  localparam int LANEW = $clog2(LANES);

  disp_state_t       st;
  logic [NW-1:0]     idx;
  logic [LANEW-1:0]  tgt;
  logic              at_end;

  assign tgt    = idx[LANEW-1:0];
  assign at_end = (idx == last_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= DP_IDLE;
      idx      <= '0;
      finished <= 1'b0;
    end else begin
      finished <= 1'b0;
      case (st)
        DP_IDLE: if (go) begin
          idx <= '0;
          st  <= DP_READ;
        end
        DP_READ: st <= DP_TEST;
        DP_TEST: begin
          if (sp_rd_data) st <= DP_SEND;
          else if (at_end) begin
            finished <= 1'b1;
            st       <= DP_IDLE;
          end else begin
            idx <= idx + 1'b1;
            st  <= DP_READ;
          end
        end
        DP_SEND: if (lane_ready[tgt]) begin
          if (at_end) begin
            finished <= 1'b1;
            st       <= DP_IDLE;
          end else begin
            idx <= idx + 1'b1;
            st  <= DP_READ;
          end
        end
        default: st <= DP_IDLE;
      endcase
    end
  end

  assign sp_rd_en   = (st == DP_READ);
  assign sp_rd_addr = {bank, ts, idx};
  assign lane_nid   = idx;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_valid[g] = (st == DP_SEND) && (tgt == LANEW'(g));
  end

  // R5
  one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_valid));

  // R5
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(lane_valid & ~lane_ready)) |=> ($stable(lane_valid) && $stable(lane_nid)));
endmodule

// File: rtl/snn_if_sweep.sv
module snn_if_sweep
  import snn_seq_pkg::*;
#(
  parameter int NW = 6,
  parameter int TW = 4,
  parameter int LW = 2,
  parameter int VW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic [LW-1:0]      layer,
  input  logic [TW-1:0]      ts,
  input  logic               wbank,
  input  logic [NW-1:0]      last_idx,
  input  logic [VW-1:0]      bias,
  input  logic [VW-1:0]      thresh,
  output logic               st_rd_en,
  output logic [LW+NW-1:0]   st_rd_addr,
  input  logic [VW-1:0]      st_rd_data,
  output logic               st_wr_en,
  output logic [LW+NW-1:0]   st_wr_addr,
  output logic [VW-1:0]      st_wr_data,
  output logic               sp_wr_en,
  output logic [TW+NW:0]     sp_wr_addr,
  output logic               sp_wr_data,
  output logic               finished
);
  eval_state_t          st;
  logic [NW-1:0]        idx;
  logic signed [VW-1:0] sum;
  logic                 fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= EV_IDLE;
      idx      <= '0;
      finished <= 1'b0;
    end else begin
      finished <= 1'b0;
      case (st)
        EV_IDLE: if (go) begin
          idx <= '0;
          st  <= EV_READ;
        end
        EV_READ: st <= EV_FIRE;
        EV_FIRE: begin
          if (idx == last_idx) begin
            finished <= 1'b1;
            st       <= EV_IDLE;
          end else begin
            idx <= idx + 1'b1;
            st  <= EV_READ;
          end
        end
        default: st <= EV_IDLE;
      endcase
    end
  end

  assign sum  = $signed(st_rd_data) + $signed(bias);
  assign fire = (sum > $signed(thresh));

  assign st_rd_en   = (st == EV_READ);
  assign st_rd_addr = {layer, idx};
  assign st_wr_en   = (st == EV_FIRE);
  assign st_wr_addr = {layer, idx};
  assign st_wr_data = fire ? '0 : sum;
  assign sp_wr_en   = (st == EV_FIRE);
  assign sp_wr_addr = {wbank, ts, idx};
  assign sp_wr_data = fire;

  // R6
  wb_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr_en |-> ($past(st_rd_en) && st_wr_addr == $past(st_rd_addr)));
endmodule

// File: rtl/snn_layer_seq.sv
module snn_layer_seq
  import snn_seq_pkg::*;
#(
  parameter int LANES = 16,
  parameter int MAXL  = 4,
  parameter int NW    = 6,
  parameter int TW    = 4,
  parameter int VW    = 16,
  localparam int LW   = $clog2(MAXL),
  localparam int SAW  = 1 + TW + NW,
  localparam int STAW = LW + NW
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  output logic                   done,
  input  logic [LW-1:0]          cfg_last_layer,
  input  logic [TW-1:0]          cfg_last_ts,
  input  logic [(MAXL+1)*NW-1:0] cfg_size,
  input  logic [MAXL-1:0]        cfg_prob,
  input  logic [MAXL*VW-1:0]     cfg_thresh,
  input  logic [MAXL*VW-1:0]     cfg_bias,
  output logic                   sp_rd_en,
  output logic [SAW-1:0]         sp_rd_addr,
  input  logic                   sp_rd_data,
  output logic                   sp_wr_en,
  output logic [SAW-1:0]         sp_wr_addr,
  output logic                   sp_wr_data,
  output logic [LANES-1:0]       lane_valid,
  input  logic [LANES-1:0]       lane_ready,
  output logic [NW-1:0]          lane_nid,
  output logic                   lane_prob,
  input  logic [LANES-1:0]       lane_busy,
  output logic                   st_rd_en,
  output logic [STAW-1:0]        st_rd_addr,
  input  logic [VW-1:0]          st_rd_data,
  output logic                   st_wr_en,
  output logic [STAW-1:0]        st_wr_addr,
  output logic [VW-1:0]          st_wr_data
);
  seq_state_t     st;
  logic [LW-1:0]  layer;
  logic [TW-1:0]  ts;
  logic           go_prop, go_eval;
  logic           prop_fin, eval_fin;
  logic [NW-1:0]  prev_last, cur_last;
  logic [VW-1:0]  cur_thresh, cur_bias;

  assign prev_last  = cfg_size[int'(layer)*NW +: NW];
  assign cur_last   = cfg_size[(int'(layer)+1)*NW +: NW];
  assign cur_thresh = cfg_thresh[int'(layer)*VW +: VW];
  assign cur_bias   = cfg_bias[int'(layer)*VW +: VW];
  assign lane_prob  = cfg_prob[layer];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= SQ_IDLE;
      layer   <= '0;
      ts      <= '0;
      go_prop <= 1'b0;
      go_eval <= 1'b0;
      done    <= 1'b0;
    end else begin
      go_prop <= 1'b0;
      go_eval <= 1'b0;
      done    <= 1'b0;
      case (st)
        SQ_IDLE: if (start) begin
          layer   <= '0;
          ts      <= '0;
          go_prop <= 1'b1;
          st      <= SQ_PROP;
        end
        SQ_PROP:   if (prop_fin) st <= SQ_SETTLE;
        SQ_SETTLE: st <= SQ_DRAIN;
        SQ_DRAIN: if (!(|lane_busy)) begin
          go_eval <= 1'b1;
          st      <= SQ_EVAL;
        end
        SQ_EVAL:   if (eval_fin) st <= SQ_NEXT;
        SQ_NEXT: begin
          if (ts == cfg_last_ts) begin
            if (layer == cfg_last_layer) begin
              done <= 1'b1;
              st   <= SQ_IDLE;
            end else begin
              layer   <= layer + 1'b1;
              ts      <= '0;
              go_prop <= 1'b1;
              st      <= SQ_PROP;
            end
          end else begin
            ts      <= ts + 1'b1;
            go_prop <= 1'b1;
            st      <= SQ_PROP;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  snn_spike_dispatch #(.LANES(LANES), .NW(NW), .TW(TW)) u_disp (
    .clk(clk), .rst_n(rst_n), .go(go_prop), .bank(layer[0]), .ts(ts),
    .last_idx(prev_last), .sp_rd_en(sp_rd_en), .sp_rd_addr(sp_rd_addr),
    .sp_rd_data(sp_rd_data), .lane_valid(lane_valid), .lane_ready(lane_ready),
    .lane_nid(lane_nid), .finished(prop_fin)
  );

  snn_if_sweep #(.NW(NW), .TW(TW), .LW(LW), .VW(VW)) u_eval (
    .clk(clk), .rst_n(rst_n), .go(go_eval), .layer(layer), .ts(ts),
    .wbank(~layer[0]), .last_idx(cur_last), .bias(cur_bias),
    .thresh(cur_thresh), .st_rd_en(st_rd_en), .st_rd_addr(st_rd_addr),
    .st_rd_data(st_rd_data), .st_wr_en(st_wr_en), .st_wr_addr(st_wr_addr),
    .st_wr_data(st_wr_data), .sp_wr_en(sp_wr_en), .sp_wr_addr(sp_wr_addr),
    .sp_wr_data(sp_wr_data), .finished(eval_fin)
  );

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  quiet_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_rd_en |-> !(|lane_busy));

  // R3
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sp_rd_en && st_rd_en));

  // R2
  layer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(layer) |-> (layer == $past(layer) + 1'b1 || layer == '0));
endmodule

// File: tb/tb_snn_layer_seq.sv
module tb_snn_layer_seq;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 16;
  localparam int MAXL  = 4;
  localparam int NW    = 6;
  localparam int TW    = 4;
  localparam int VW    = 16;
  localparam int LW    = 2;
  localparam int SAW   = 1 + TW + NW;
  localparam int STAW  = LW + NW;
  localparam int LOGN  = 16384;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, done;
  logic [LW-1:0] cfg_last_layer = '0;
  logic [TW-1:0] cfg_last_ts = '0;
  logic [(MAXL+1)*NW-1:0] cfg_size = '0;
  logic [MAXL-1:0] cfg_prob = '0;
  logic [MAXL*VW-1:0] cfg_thresh = '0, cfg_bias = '0;
  logic sp_rd_en, sp_rd_data = 1'b0, sp_wr_en, sp_wr_data;
  logic [SAW-1:0] sp_rd_addr, sp_wr_addr;
  logic [LANES-1:0] lane_valid, lane_ready = '0, lane_busy = '0;
  logic [NW-1:0] lane_nid;
  logic lane_prob;
  logic st_rd_en, st_wr_en;
  logic [STAW-1:0] st_rd_addr, st_wr_addr;
  logic [VW-1:0] st_rd_data = '0, st_wr_data;

  snn_layer_seq #(.LANES(LANES), .MAXL(MAXL), .NW(NW), .TW(TW), .VW(VW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .cfg_last_layer(cfg_last_layer), .cfg_last_ts(cfg_last_ts),
    .cfg_size(cfg_size), .cfg_prob(cfg_prob), .cfg_thresh(cfg_thresh),
    .cfg_bias(cfg_bias), .sp_rd_en(sp_rd_en), .sp_rd_addr(sp_rd_addr),
    .sp_rd_data(sp_rd_data), .sp_wr_en(sp_wr_en), .sp_wr_addr(sp_wr_addr),
    .sp_wr_data(sp_wr_data), .lane_valid(lane_valid), .lane_ready(lane_ready),
    .lane_nid(lane_nid), .lane_prob(lane_prob), .lane_busy(lane_busy),
    .st_rd_en(st_rd_en), .st_rd_addr(st_rd_addr), .st_rd_data(st_rd_data),
    .st_wr_en(st_wr_en), .st_wr_addr(st_wr_addr), .st_wr_data(st_wr_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // memories with a host write port used for preloading
  logic spk_mem [0:(1<<SAW)-1];
  logic [VW-1:0] st_mem [0:(1<<STAW)-1];
  logic hs_we = 1'b0, hst_we = 1'b0, hs_d = 1'b0;
  logic [SAW-1:0] hs_a = '0;
  logic [STAW-1:0] hst_a = '0;
  logic [VW-1:0] hst_d = '0;

  always @(posedge clk) begin
    if (sp_rd_en) sp_rd_data <= spk_mem[sp_rd_addr];
    if (st_rd_en) st_rd_data <= st_mem[st_rd_addr];
    if (hs_we) spk_mem[hs_a] <= hs_d;
    else if (sp_wr_en) spk_mem[sp_wr_addr] <= sp_wr_data;
    if (hst_we) st_mem[hst_a] <= hst_d;
    else if (st_wr_en) st_mem[st_wr_addr] <= st_wr_data;
  end

  // expected data
  int exp_nid [0:LOGN-1];
  int exp_prb [0:LOGN-1];
  int exp_rda [0:LOGN-1];
  int exp_cum [0:LOGN-1];
  int n_exp_disp = 0, n_exp_rd = 0;
  logic m_spk [0:(1<<SAW)-1];
  logic [VW-1:0] m_st [0:(1<<STAW)-1];

  // observed (monitor-owned)
  int got_nid [0:LOGN-1];
  int got_prb [0:LOGN-1];
  int n_got = 0, rd_k = 0, done_seen = 0;
  int mon_checks = 0, mon_errs = 0;
  int busy_cnt [LANES];
  int checks = 0, errors = 0;

  function automatic int sa(int b, int t, int n);
    return (b << (TW+NW)) | (t << NW) | n;
  endfunction
  function automatic int sta(int l, int n);
    return (l << NW) | n;
  endfunction
  function automatic int gsize(int k);
    return int'(cfg_size[k*NW +: NW]);
  endfunction

  // lane model and cycle monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      lane_ready = '0;
      lane_busy  = '0;
      for (int i = 0; i < LANES; i++) busy_cnt[i] = 0;
    end else begin
      for (int i = 0; i < LANES; i++) begin
        if (busy_cnt[i] > 0) busy_cnt[i]--;
        lane_ready[i] = ($urandom % 4) != 0;
        if (lane_valid[i] && lane_ready[i]) begin
          got_nid[n_got] = int'(lane_nid);
          got_prb[n_got] = int'(lane_prob);
          n_got++;
          busy_cnt[i] = 1 + ($urandom % 5);
        end
        lane_busy[i] = (busy_cnt[i] != 0);
      end
      if (st_rd_en) begin
        // R2 R3 R6: state read order, and all spikes delivered with lanes quiet
        mon_checks++;
        if (rd_k >= n_exp_rd || int'(st_rd_addr) != exp_rda[rd_k] ||
            n_got != exp_cum[rd_k] || lane_busy != '0) begin
          mon_errs++;
          $display("FAIL R3 read %0d: addr %0d delivered %0d busy %h, expected addr %0d delivered %0d busy 0",
                   rd_k, st_rd_addr, n_got, lane_busy,
                   (rd_k < n_exp_rd) ? exp_rda[rd_k] : -1,
                   (rd_k < n_exp_rd) ? exp_cum[rd_k] : -1);
        end
        rd_k++;
      end
      if (done) done_seen++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic wr_spk(input int a, input bit d);
    hs_we = 1'b1; hs_a = SAW'(a); hs_d = d;
    @(negedge clk);
    hs_we = 1'b0;
  endtask

  task automatic wr_st(input int a, input int d);
    hst_we = 1'b1; hst_a = STAW'(a); hst_d = VW'(d);
    @(negedge clk);
    hst_we = 1'b0;
  endtask

  task automatic prepare(input int density);
    for (int a = 0; a < (1<<SAW); a++) wr_spk(a, 1'b0);
    for (int t = 0; t <= int'(cfg_last_ts); t++)
      for (int n = 0; n <= gsize(0); n++)
        if (($urandom % 100) < density) wr_spk(sa(0, t, n), 1'b1);
    for (int a = 0; a < (1<<STAW); a++) wr_st(a, $urandom % 20);
  endtask

  task automatic build_expect();
    int sum, thr, bia;
    bit f;
    for (int a = 0; a < (1<<SAW); a++) m_spk[a] = spk_mem[a];
    for (int a = 0; a < (1<<STAW); a++) m_st[a] = st_mem[a];
    for (int l = 0; l <= int'(cfg_last_layer); l++) begin
      thr = int'($signed(cfg_thresh[l*VW +: VW]));
      bia = int'($signed(cfg_bias[l*VW +: VW]));
      for (int t = 0; t <= int'(cfg_last_ts); t++) begin
        for (int n = 0; n <= gsize(l); n++)
          if (m_spk[sa(l % 2, t, n)]) begin
            exp_nid[n_exp_disp] = n;
            exp_prb[n_exp_disp] = int'(cfg_prob[l]);
            n_exp_disp++;
          end
        for (int n = 0; n <= gsize(l+1); n++) begin
          exp_rda[n_exp_rd] = sta(l, n);
          exp_cum[n_exp_rd] = n_exp_disp;
          n_exp_rd++;
          sum = int'($signed(m_st[sta(l, n)])) + bia;
          f = (sum > thr);
          m_st[sta(l, n)] = f ? '0 : VW'(sum);
          m_spk[sa(1 - (l % 2), t, n)] = f;
        end
      end
    end
  endtask

  task automatic run_case(input string name, input bit stray_start);
    int base_got, base_exp, done0, cyc, bad;
    bit fin;
    base_exp = n_exp_disp;
    build_expect();
    base_got = n_got;
    done0 = done_seen;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    fin = 1'b0;
    for (cyc = 0; cyc < 40000 && !fin; cyc++) begin
      if (stray_start && cyc == 40) start = 1'b1;
      else start = 1'b0;
      @(negedge clk);
      if (done_seen != done0) fin = 1'b1;
    end
    start = 1'b0;
    // R9: watchdog, run must finish
    check(fin, {"R9 done reached in ", name}, int'(fin), 1);
    repeat (6) @(negedge clk);
    // R9: exactly one done pulse, stray start ignored
    check(done_seen - done0 == 1, {"R9 done count ", name}, done_seen - done0, 1);
    // R5: no spike dropped or duplicated
    check(n_got - base_got == n_exp_disp - base_exp, {"R5 dispatch count ", name},
          n_got - base_got, n_exp_disp - base_exp);
    // R4 R8: order, lane index and mode of every spike
    bad = -1;
    for (int i = 0; i < n_got - base_got && i < n_exp_disp - base_exp; i++)
      if (bad < 0 && (got_nid[base_got+i] != exp_nid[base_exp+i] ||
                      got_prb[base_got+i] != exp_prb[base_exp+i])) bad = i;
    check(bad < 0, {"R4 R8 dispatch sequence ", name},
          (bad < 0) ? 0 : got_nid[base_got+bad]*2 + got_prb[base_got+bad],
          (bad < 0) ? 0 : exp_nid[base_exp+bad]*2 + exp_prb[base_exp+bad]);
    // R7: final spike bitmap in both banks
    bad = -1;
    for (int a = 0; a < (1<<SAW); a++) if (bad < 0 && spk_mem[a] !== m_spk[a]) bad = a;
    check(bad < 0, {"R7 spike bitmap ", name}, bad, -1);
    // R6: final potentials
    bad = -1;
    for (int a = 0; a < (1<<STAW); a++) if (bad < 0 && st_mem[a] !== m_st[a]) bad = a;
    check(bad < 0, {"R6 potentials ", name},
          (bad < 0) ? 0 : int'(st_mem[bad]), (bad < 0) ? 0 : int'(m_st[bad]));
  endtask

  task automatic rand_cfg(input int layers, input int big);
    cfg_last_layer = LW'(layers - 1);
    cfg_last_ts = TW'(1 + $urandom % 4);
    for (int k = 0; k <= MAXL; k++)
      cfg_size[k*NW +: NW] = big ? NW'(63 - ($urandom % 4)) : NW'(3 + $urandom % 30);
    cfg_prob = MAXL'($urandom);
    for (int l = 0; l < MAXL; l++) begin
      cfg_thresh[l*VW +: VW] = VW'(20 + $urandom % 40);
      cfg_bias[l*VW +: VW]   = VW'(int'($urandom % 20) - 4);
    end
  endtask

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(done == 1'b0, "R1 done low", int'(done), 0);
    check(lane_valid == '0, "R1 lane valid low", int'(lane_valid), 0);
    check(!sp_rd_en && !sp_wr_en, "R1 bitmap strobes low", int'({sp_rd_en, sp_wr_en}), 0);
    check(!st_rd_en && !st_wr_en, "R1 state strobes low", int'({st_rd_en, st_wr_en}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed: two layers, threshold equality, stray start mid-run
    cfg_last_layer = 2'd1;
    cfg_last_ts = 4'd2;
    cfg_size = '0;
    cfg_size[0*NW +: NW] = 6'd9;
    cfg_size[1*NW +: NW] = 6'd7;
    cfg_size[2*NW +: NW] = 6'd5;
    cfg_prob = 4'b0010;
    cfg_thresh = '0;
    cfg_bias = '0;
    cfg_thresh[0 +: VW] = 16'd30; cfg_bias[0 +: VW] = 16'd5;
    cfg_thresh[VW +: VW] = 16'd12; cfg_bias[VW +: VW] = 16'hFFFE;
    prepare(50);
    wr_st(sta(0, 0), 25);
    wr_st(sta(0, 1), 26);
    run_case("directed", 1'b1);
    // R6: sum equal to threshold does not fire, one above does
    check(spk_mem[sa(1, 0, 0)] == 1'b0, "R6 equality no fire", int'(spk_mem[sa(1, 0, 0)]), 0);
    check(spk_mem[sa(1, 0, 1)] == 1'b1, "R6 above threshold fires", int'(spk_mem[sa(1, 0, 1)]), 1);

    // empty input: first layer dispatches nothing
    rand_cfg(3, 0);
    prepare(0);
    run_case("empty input", 1'b0);

    // random multi-layer cases
    rand_cfg(4, 0);
    prepare(40);
    run_case("random four layers", 1'b0);
    rand_cfg(3, 1);
    prepare(25);
    run_case("random wide layers", 1'b1);

    checks = checks + mon_checks;
    errors = errors + mon_errs;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule